// File: doc/BRIEF.md
# Refresh and Self-Refresh Controller

This block decides when a DRAM-style memory must receive an auto-refresh command and runs the memory's self-refresh entry and exit. An interval timer builds up a count of refreshes owed. The controller raises a request toward the command arbiter and holds it until the arbiter acknowledges that the refresh was issued. No row address is produced, because the device counts its own rows.

There are two scheduling schemes, picked by a mode input. In spread scheduling, one refresh becomes owed each time the interval timer expires. In block scheduling, the whole row population becomes owed at the start of each retention period. The owed refreshes are then requested back to back, spaced by the row cycle time.

A self-refresh request moves the controller through its sleep states. It drops the clock enable, waits for the request to be withdrawn, and then waits for the clock-stable input. It then raises the clock enable and holds a NOP-only window for a fixed number of cycles before normal work resumes.

Top module: `refresh_sr_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the state is IDLE, the request is low, the clock enable is high, and the NOP-only and self-refresh command outputs are low.
- R2: In spread mode (block_mode_i=0), the timer expires every INTERVAL_CYC cycles spent in IDLE or REFRESH_PENDING. Each expiry adds one owed refresh, saturating at ROWS. The timer restarts from zero on reset and after self-refresh exit.
- R3: In block mode (block_mode_i=1), the timer expires every PERIOD_CYC cycles. Each expiry sets the owed count to ROWS.
- R4: After an acknowledged refresh, the next request rises no earlier than TRC_CYC clock edges after the acknowledging edge.
- R5: A request stays high until acknowledged, and each acknowledge removes one owed refresh. An acknowledge while no request is high has no effect.
- R6: Self-refresh is entered from IDLE only. A refresh that can start in that cycle wins over a self-refresh request. The SR_ENTER state lasts one cycle, with sr_cmd_o high and the clock enable low.
- R7: The clock enable is low in SR_ENTER, SR_ACTIVE and SR_WAIT_CLK. It rises only on the edge after clk_stable_i is seen high in SR_WAIT_CLK, and SR_WAIT_CLK is reached only once sr_req_i is low.
- R8: After the clock enable rises, the controller stays in SR_EXIT_NOP with nop_only_o high for exactly TSRX_CYC cycles, then returns to IDLE with the owed count cleared.
- R9: nop_only_o is high in every self-refresh state, and no refresh is requested in those states.
- R10: The state is output as IDLE=0, REFRESH_PENDING=1, SR_ENTER=2, SR_ACTIVE=3, SR_WAIT_CLK=4, SR_EXIT_NOP=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| block_mode_i | input | 1 | 0 = spread scheduling, 1 = block scheduling; change only under reset |
| ref_ack_i | input | 1 | Arbiter has issued the requested auto-refresh |
| sr_req_i | input | 1 | Request to enter and stay in self-refresh |
| clk_stable_i | input | 1 | Memory clock is stable; exit may proceed |
| ref_req_o | output | 1 | Auto-refresh request, held until acknowledged |
| sr_cmd_o | output | 1 | Issue the self-refresh entry command this cycle |
| cke_o | output | 1 | Clock enable toward the memory |
| nop_only_o | output | 1 | Arbiter may issue NOP commands only |
| state_o | output | 3 | Current controller state |

## Verification
A wrong state shows on state_o and on the decoded outputs in the same cycle. A corrupted owed count or spacing counter only shows later, as a request that comes too early, too late, or one time too many. The model is compared on every cycle, so such a fault is caught on the first request edge that differs. Saturation is exercised by withholding acknowledges over several intervals. The exit window is exercised by holding clk_stable_i low for several cycles.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE        = 3'd0,
    ST_REF_PEND    = 3'd1,
    ST_SR_ENTER    = 3'd2,
    ST_SR_ACTIVE   = 3'd3,
    ST_SR_WAIT_CLK = 3'd4,
    ST_SR_EXIT_NOP = 3'd5
  } rsr_state_e;
endpackage

// File: rtl/rsr_tick_timer.sv
module rsr_tick_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign wrap_o = !clear_i && (cnt_q == limit_i - 1'b1);

  always_comb begin
    if (clear_i || wrap_o) cnt_n = '0;
    else                   cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/rsr_refresh_debt.sv
module rsr_refresh_debt #(
  parameter int unsigned ROWS = 2048,
  parameter int unsigned TRC  = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic block_i,
  input  logic take_i,
  input  logic flush_i,
  output logic owed_nz_o,
  output logic gap_busy_o
);
  localparam int unsigned OW = $clog2(ROWS + 1);
  localparam int unsigned GW = (TRC > 1) ? $clog2(TRC) : 1;

  logic [OW-1:0] owed_q, owed_n;
  logic [OW:0]   sum;
  logic [GW-1:0] gap_q, gap_n;

  always_comb begin
    sum = {1'b0, owed_q} + {{OW{1'b0}}, tick_i} - {{OW{1'b0}}, take_i};
    if (flush_i)                 owed_n = '0;
    else if (tick_i && block_i)  owed_n = OW'(ROWS);
    else if (sum > (OW+1)'(ROWS)) owed_n = OW'(ROWS);
    else                          owed_n = sum[OW-1:0];
  end

  always_comb begin
    if (take_i)          gap_n = GW'(TRC - 1);
    else if (gap_q != 0) gap_n = gap_q - 1'b1;
    else                 gap_n = gap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
      gap_q  <= '0;
    end else begin
      owed_q <= owed_n;
      gap_q  <= gap_n;
    end
  end

  assign owed_nz_o  = (owed_q != '0);
  assign gap_busy_o = (gap_q != '0);

  AST_OWED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OW'(ROWS)); // R2
  AST_GAP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (TRC > 1) && take_i |=> gap_busy_o); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !owed_nz_o); // R8
endmodule

// File: rtl/rsr_fsm.sv
module rsr_fsm
  import rsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       owed_nz_i,
  input  logic       gap_busy_i,
  input  logic       sr_req_i,
  input  logic       clk_stable_i,
  input  logic       ack_i,
  input  logic       win_done_i,
  output rsr_state_e state_o
);
  rsr_state_e st_q, st_n;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (owed_nz_i && !gap_busy_i) st_n = ST_REF_PEND;
        else if (sr_req_i)            st_n = ST_SR_ENTER;
      end
      ST_REF_PEND:    if (ack_i)         st_n = ST_IDLE;
      ST_SR_ENTER:                       st_n = ST_SR_ACTIVE;
      ST_SR_ACTIVE:   if (!sr_req_i)     st_n = ST_SR_WAIT_CLK;
      ST_SR_WAIT_CLK: if (clk_stable_i)  st_n = ST_SR_EXIT_NOP;
      ST_SR_EXIT_NOP: if (win_done_i)    st_n = ST_IDLE;
      default:                           st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_n;
  end

  assign state_o = st_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REF_PEND) && !ack_i |=> (st_q == ST_REF_PEND)); // R5
  AST_SR_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SR_ENTER) |-> ($past(st_q) == ST_IDLE) && $past(sr_req_i)); // R6
  AST_ENTER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SR_ENTER) |=> (st_q == ST_SR_ACTIVE)); // R6
endmodule

// File: rtl/refresh_sr_ctrl.sv
module refresh_sr_ctrl
  import rsr_pkg::*;
#(
  parameter int unsigned ROWS         = 2048,
  parameter int unsigned INTERVAL_CYC = 3120,
  parameter int unsigned PERIOD_CYC   = 6400000,
  parameter int unsigned TRC_CYC      = 14,
  parameter int unsigned TSRX_CYC     = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       block_mode_i,
  input  logic       ref_ack_i,
  input  logic       sr_req_i,
  input  logic       clk_stable_i,
  output logic       ref_req_o,
  output logic       sr_cmd_o,
  output logic       cke_o,
  output logic       nop_only_o,
  output logic [2:0] state_o
);
  localparam int unsigned MAX_A = (PERIOD_CYC > INTERVAL_CYC) ? PERIOD_CYC : INTERVAL_CYC;
  localparam int unsigned MAX_C = (MAX_A > TSRX_CYC) ? MAX_A : TSRX_CYC;
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);

  rsr_state_e       st;
  logic [CNT_W-1:0] limit;
  logic             asleep, wrap, tick, take, flush, owed_nz, gap_busy;

  assign asleep = (st == ST_SR_ENTER) || (st == ST_SR_ACTIVE) || (st == ST_SR_WAIT_CLK);
  assign tick   = wrap && ((st == ST_IDLE) || (st == ST_REF_PEND));
  assign flush  = wrap && (st == ST_SR_EXIT_NOP);
  assign take   = (st == ST_REF_PEND) && ref_ack_i;

  always_comb begin
    if (st == ST_SR_EXIT_NOP) limit = CNT_W'(TSRX_CYC);
    else if (block_mode_i)    limit = CNT_W'(PERIOD_CYC);
    else                      limit = CNT_W'(INTERVAL_CYC);
  end

  rsr_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear_i(asleep), .limit_i(limit), .wrap_o(wrap)
  );

  rsr_refresh_debt #(.ROWS(ROWS), .TRC(TRC_CYC)) u_debt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .block_i(block_mode_i),
    .take_i(take), .flush_i(flush), .owed_nz_o(owed_nz), .gap_busy_o(gap_busy)
  );

  rsr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .owed_nz_i(owed_nz), .gap_busy_i(gap_busy),
    .sr_req_i(sr_req_i), .clk_stable_i(clk_stable_i), .ack_i(ref_ack_i),
    .win_done_i(flush), .state_o(st)
  );

  assign ref_req_o  = (st == ST_REF_PEND);
  assign sr_cmd_o   = (st == ST_SR_ENTER);
  assign cke_o      = !asleep;
  assign nop_only_o = asleep || (st == ST_SR_EXIT_NOP);
  assign state_o    = st;

  AST_CKE_NEEDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |-> $past(clk_stable_i)); // R7
  AST_NOP_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |-> nop_only_o && (st == ST_SR_EXIT_NOP)); // R8
  AST_NO_REQ_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    nop_only_o |-> !ref_req_o); // R9
endmodule

// File: tb/test_refresh_sr_ctrl.sv
`timescale 1ns/1ps
module test_refresh_sr_ctrl;
  localparam int ROWS = 3, IVL = 12, PER = 40, TRC = 3, TSRX = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic block_mode = 1'b0, sr_req = 1'b0, clk_stable = 1'b0;
  logic ack_drv = 1'b0, spur = 1'b0, ack_en = 1'b0;
  logic ref_ack;
  logic ref_req, sr_cmd, cke, nop_only;
  logic [2:0] state;
  int checks = 0, failures = 0, cyc = 0, last_ack = -1000, wait_cnt = 0;
  int m_st = 0, m_tmr = 0, m_owed = 0, m_gap = 0;
  logic prev_req = 1'b0;
  bit done = 0;

  assign ref_ack = ack_drv | spur;
  always #2.5 clk = ~clk;

  refresh_sr_ctrl #(.ROWS(ROWS), .INTERVAL_CYC(IVL), .PERIOD_CYC(PER),
                    .TRC_CYC(TRC), .TSRX_CYC(TSRX)) i_refresh_sr_ctrl (
    .clk(clk), .rst_n(rst_n), .block_mode_i(block_mode), .ref_ack_i(ref_ack),
    .sr_req_i(sr_req), .clk_stable_i(clk_stable), .ref_req_o(ref_req),
    .sr_cmd_o(sr_cmd), .cke_o(cke), .nop_only_o(nop_only), .state_o(state)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_tmr = 0; m_owed = 0; m_gap = 0;
    end else begin
      int lim, nst, nowed;
      bit asleep, wrap, tick, take;
      cyc++;
      asleep = (m_st >= 2 && m_st <= 4);
      lim = (m_st == 5) ? TSRX : (block_mode ? PER : IVL);
      wrap = !asleep && (m_tmr == lim - 1);
      tick = wrap && (m_st <= 1);
      take = (m_st == 1) && ref_ack;
      if (take) last_ack = cyc;
      nst = m_st;
      case (m_st)
        0: if (m_owed > 0 && m_gap == 0) nst = 1; else if (sr_req) nst = 2;
        1: if (ref_ack) nst = 0;
        2: nst = 3;
        3: if (!sr_req) nst = 4;
        4: if (clk_stable) nst = 5;
        5: if (wrap) nst = 0;
        default: nst = 0;
      endcase
      if (m_st == 5 && wrap) nowed = 0;
      else if (tick && block_mode) nowed = ROWS;
      else begin
        nowed = m_owed + (tick ? 1 : 0) - (take ? 1 : 0);
        if (nowed > ROWS) nowed = ROWS;
      end
      m_gap = take ? TRC - 1 : (m_gap > 0 ? m_gap - 1 : 0);
      m_tmr = (asleep || wrap) ? 0 : m_tmr + 1;
      m_owed = nowed;
      m_st = nst;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 state", state, m_st);
      chk(block_mode ? "R3 ref_req" : "R2 ref_req", ref_req, m_st == 1);
      chk("R6 sr_cmd", sr_cmd, m_st == 2);
      chk("R7 cke", cke, !(m_st >= 2 && m_st <= 4));
      chk(m_st == 5 ? "R8 nop_only" : "R9 nop_only", nop_only, m_st >= 2);
      if (ref_req && !prev_req)
        chk("R4 spacing ok", (cyc - last_ack) >= TRC, 1);
      prev_req = ref_req;
    end
  end

  // arbiter model: acknowledges after a random delay
  always @(negedge clk) begin
    if (ack_en && ref_req && !ack_drv) begin
      if (wait_cnt == 0) begin
        ack_drv <= 1'b1;
        wait_cnt = $urandom_range(0, 3);
      end else wait_cnt--;
    end else ack_drv <= 1'b0;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; block_mode = mode;
    cycles(2);
    chk("R1 state in reset", state, 0);
    chk("R1 cke in reset", cke, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state", state, 0);
    chk("R1 ref_req", ref_req, 0);
    chk("R1 cke", cke, 1);
    chk("R1 nop_only", nop_only, 0);
    chk("R1 sr_cmd", sr_cmd, 0);
  endtask

  task automatic sleep_cycle(input int hold, input int stab_wait);
    sr_req = 1'b1;
    cycles(hold);
    sr_req = 1'b0;
    cycles(stab_wait);
    chk("R7 cke low while clock unstable", cke, 0);
    clk_stable = 1'b1;
    cycles(TSRX + 3);
    clk_stable = 1'b0;
  endtask

  initial begin
    do_reset(1'b0);
    ack_en = 1'b1;
    cycles(120);
    // withheld acknowledges: debt saturates, request is held
    ack_en = 1'b0;
    cycles(5 * IVL);
    chk("R5 request held without ack", ref_req, 1);
    ack_en = 1'b1;
    cycles(60);
    // stray acknowledge while idle
    @(negedge clk);
    while (ref_req) @(negedge clk);
    spur = 1'b1;
    @(negedge clk);
    spur = 1'b0;
    cycles(40);
    // self-refresh in spread mode
    sleep_cycle(15, 7);
    cycles(50);
    // self-refresh requested while a refresh is owed
    ack_en = 1'b0;
    cycles(IVL + 2);
    sr_req = 1'b1;
    cycles(3);
    chk("R6 pending refresh blocks sleep", state, 1);
    ack_en = 1'b1;
    cycles(12);
    sr_req = 1'b0;
    cycles(3);
    clk_stable = 1'b1;
    cycles(TSRX + 3);
    clk_stable = 1'b0;
    cycles(40);
    // block mode
    do_reset(1'b1);
    cycles(3 * PER);
    sleep_cycle(10, 3);
    cycles(2 * PER);
    ack_en = 1'b0;
    cycles(PER + 5);
    chk("R5 block request held", ref_req, 1);
    ack_en = 1'b1;
    cycles(PER);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule